// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Command Capture

This block holds the bytes that move between a host register port and the SCSI side of a controller when transfers are done by programmed I/O. A 16-entry byte buffer is filled by host writes and emptied by host reads. It is addressed by a write pointer and a read pointer that never wrap. Beside the buffer it keeps a signed count of the bytes still expected in the transfer. When the buffer drains, both pointers return to zero. A write that arrives while the write pointer sits on the last entry is dropped and reported as overrun.

A level input selects command-capture mode. In that mode, host writes to the FIFO address go into a separate 32-byte command buffer, which the sequencing logic reads back through an indexed port and empties with a take strobe. A preload strobe from the sequencing side places a status byte and a zero message byte at the head of the data buffer and raises the interrupt. A flush command sets the interrupt cause to function-complete and clears the sequence-step and FIFO-flags registers. The host clears the interrupt with an acknowledge strobe.

Top module: `pio_cmd_fifo`

## Requirements
- R1: After reset: read data 0, count 0, FIFO flags 0, cause 0, sequence step 0, irq low, command length 0, overrun low, and both pointers at 0.
- R2: When command mode is off and the write pointer is below 15, a host write stores the byte, advances the write pointer and adds 1 to the count. When the write pointer equals 15, the write is dropped, pointers and count do not change, and overrun_o is high for exactly the one cycle after the write edge. At most 15 bytes fit.
- R3: In command mode, a host write appends the byte to the command buffer at index cmd_len_o and increments cmd_len_o while it is below 32. At 32 the write is dropped and flagged as overrun. The data buffer and the count are untouched. cmd_take_i empties the command buffer and wins over a write in the same cycle, which is then dropped with no overrun. cmd_rdata_o returns entry cmd_raddr_i when that index is below cmd_len_o, and 0 otherwise.
- R4: A host read with phase_i not equal to 0 and data present returns the oldest unread byte on fifo_rdata_o from the next cycle and subtracts 1 from the count. A read of an empty buffer leaves fifo_rdata_o and the count unchanged.
- R5: A host read with phase_i equal to 0 (data-out) sets fifo_rdata_o to 0 and leaves the pointers and the count unchanged.
- R6: When a read leaves the read pointer equal to the write pointer, both pointers return to 0. After a full drain, 15 more writes are accepted. Before the drain, reading part of the buffer frees no room.
- R7: status_load_i writes status_byte_i to entry 0 and 0x00 to entry 1, sets the read pointer to 0, the write pointer to 2, the count to 2 and the FIFO flags to 2, and raises irq_o.
- R8: flush_i sets int_cause_o to function-complete (0x08) and clears the sequence step and the FIFO flags. A preload in the same cycle still sets the flags to 2.
- R9: int_ack_i lowers irq_o and clears the cause unless a preload (for irq) or a flush (for cause) occurs in the same cycle. seq_wr_i loads seq_val_i into the sequence step unless a flush occurs in the same cycle.
- R10: Priorities when strobes coincide: a preload drops any host access in its cycle; a host write drops a host read in its cycle; count_load_i sets the count to count_val_i over any other count change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_wr_i | input | 1 | Host write strobe to the FIFO address |
| fifo_wdata_i | input | 8 | Host write byte |
| fifo_rd_i | input | 1 | Host read strobe from the FIFO address |
| phase_i | input | 3 | Bus phase bits; 0 means data-out |
| fifo_rdata_o | output | 8 | FIFO read data register |
| cmd_mode_i | input | 1 | Command-capture mode level |
| cmd_take_i | input | 1 | Empties the command buffer |
| cmd_raddr_i | input | 5 | Command buffer read index |
| cmd_rdata_o | output | 8 | Command byte at cmd_raddr_i |
| cmd_len_o | output | 6 | Bytes held in the command buffer |
| status_load_i | input | 1 | Preload status and message bytes |
| status_byte_i | input | 8 | Status byte for preload |
| count_load_i | input | 1 | Load the expected-byte count |
| count_val_i | input | 17 | Signed count load value |
| count_o | output | 17 | Signed expected-byte count |
| flush_i | input | 1 | Flush command |
| int_ack_i | input | 1 | Interrupt acknowledge |
| seq_wr_i | input | 1 | Sequence-step load |
| seq_val_i | input | 3 | Sequence-step value |
| seq_step_o | output | 3 | Sequence-step register |
| int_cause_o | output | 8 | Interrupt cause register |
| fifo_flags_o | output | 5 | FIFO-flags register |
| irq_o | output | 1 | Interrupt request level |
| overrun_o | output | 1 | One-cycle overrun pulse |

## Verification
Every register result (read data, count, flags, cause, sequence step, irq, command length and the overrun pulse) changes at the first clock edge after the strobe and is valid from then on. cmd_rdata_o is combinational on the stored state and the index. The bench drives each strobe for a single cycle starting at a falling edge. At the next rising edge it steps a queue-based reference model, and at the following falling edge it compares every output against that model, so each comparison lands one full register stage after its stimulus. Directed checks at the same sampling point cover the reset values, the data-out read, the drain refill and the coincident-strobe priorities.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;
  localparam logic [7:0] CAUSE_FUNC_DONE = 8'h08;
  localparam logic [2:0] PHASE_DATA_OUT  = 3'd0;
endpackage

// File: rtl/pio_data_buf.sv
module pio_data_buf #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int CNT_W = 17
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [W-1:0]            wdata_i,
  input  logic                    rd_i,
  input  logic                    phase_zero_i,
  input  logic                    preload_i,
  input  logic [W-1:0]            status_i,
  input  logic                    cnt_load_i,
  input  logic signed [CNT_W-1:0] cnt_val_i,
  output logic [W-1:0]            rdata_o,
  output logic signed [CNT_W-1:0] count_o,
  output logic                    overrun_o
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [PW-1:0] TWO  = PW'(2);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic          at_last, wr_ok, rd_act, rd_ok;
  logic [PW-1:0] rptr_nxt;

  assign at_last  = (wptr_q == LAST);
  assign wr_ok    = wr_i & ~preload_i & ~at_last;
  assign rd_act   = rd_i & ~preload_i & ~wr_i;
  assign rd_ok    = rd_act & ~phase_zero_i & (rptr_q < wptr_q);
  assign rptr_nxt = rd_ok ? rptr_q + PW'(1) : rptr_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (preload_i && g == 0)              mem_q[g] <= status_i;
      else if (preload_i && g == 1)         mem_q[g] <= '0;
      else if (wr_ok && wptr_q == PW'(g))   mem_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (preload_i) begin
      wptr_q <= TWO;
      rptr_q <= '0;
    end else if (wr_ok) begin
      wptr_q <= wptr_q + PW'(1);
    end else if (rd_act) begin
      if (rptr_nxt == wptr_q) begin
        wptr_q <= '0;
        rptr_q <= '0;
      end else begin
        rptr_q <= rptr_nxt;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    rdata_o <= '0;
    else if (rd_act && phase_zero_i) rdata_o <= '0;
    else if (rd_ok)                 rdata_o <= mem_q[rptr_q];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        count_o <= '0;
    else if (cnt_load_i) count_o <= cnt_val_i;
    else if (preload_i) count_o <= CNT_W'(2);
    else if (wr_ok)     count_o <= count_o + CNT_W'(1);
    else if (rd_ok)     count_o <= count_o - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) overrun_o <= 1'b0;
    else         overrun_o <= wr_i & ~preload_i & at_last;
  end

  assert_drop_at_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !preload_i && at_last) |=> (overrun_o && $stable(wptr_q)));
  assert_data_out_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act && phase_zero_i && !cnt_load_i) |=> (rdata_o == '0 && $stable(count_o) && $stable(rptr_q)));
  assert_drain_snap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_act |=> ((rptr_q != wptr_q) || (rptr_q == '0 && wptr_q == '0)));
  assert_preload_ptrs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preload_i |=> (wptr_q == TWO && rptr_q == '0));
endmodule

// File: rtl/pio_cmd_buf.sv
module pio_cmd_buf #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          take_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o,
  output logic [LW-1:0] len_o,
  output logic          overrun_o
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic         full, app;

  assign full = (len_o == FULL);
  assign app  = wr_i & ~take_i & ~full;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (app && len_o == LW'(g)) mem_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     len_o <= '0;
    else if (take_i) len_o <= '0;
    else if (app)    len_o <= len_o + LW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) overrun_o <= 1'b0;
    else         overrun_o <= wr_i & ~take_i & full;
  end

  assign rdata_o = ({1'b0, raddr_i} < len_o) ? mem_q[raddr_i] : '0;

  assert_cmd_append_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !take_i && !full) |=> (len_o == $past(len_o) + LW'(1)));
  assert_cmd_full_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !take_i && full) |=> (overrun_o && $stable(len_o)));
endmodule

// File: rtl/pio_int_regs.sv
module pio_int_regs
  import pio_fifo_pkg::*;
#(
  parameter int FLAG_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              ack_i,
  input  logic              raise_i,
  input  logic              seq_wr_i,
  input  logic [2:0]        seq_val_i,
  output logic [7:0]        cause_o,
  output logic [2:0]        seq_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_o <= '0;
      seq_o   <= '0;
      flags_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      if (flush_i)     cause_o <= CAUSE_FUNC_DONE;
      else if (ack_i)  cause_o <= '0;
      if (flush_i)       seq_o <= '0;
      else if (seq_wr_i) seq_o <= seq_val_i;
      if (raise_i)      flags_o <= FLAG_W'(2);
      else if (flush_i) flags_o <= '0;
      if (raise_i)     irq_o <= 1'b1;
      else if (ack_i)  irq_o <= 1'b0;
    end
  end

  assert_flush_regs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cause_o == CAUSE_FUNC_DONE && seq_o == '0 && (flags_o == '0 || $past(raise_i))));
  assert_ack_lowers_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !raise_i) |=> !irq_o);
  assert_raise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_i |=> (irq_o && flags_o == FLAG_W'(2)));
endmodule

// File: rtl/pio_cmd_fifo.sv
module pio_cmd_fifo
  import pio_fifo_pkg::*;
#(
  parameter int DATA_DEPTH = 16,
  parameter int CMD_DEPTH  = 32,
  parameter int CNT_W      = 17,
  localparam int CAW       = $clog2(CMD_DEPTH),
  localparam int CLW       = $clog2(CMD_DEPTH + 1),
  localparam int FLAG_W    = $clog2(DATA_DEPTH) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fifo_wr_i,
  input  logic [7:0]              fifo_wdata_i,
  input  logic                    fifo_rd_i,
  input  logic [2:0]              phase_i,
  output logic [7:0]              fifo_rdata_o,
  input  logic                    cmd_mode_i,
  input  logic                    cmd_take_i,
  input  logic [CAW-1:0]          cmd_raddr_i,
  output logic [7:0]              cmd_rdata_o,
  output logic [CLW-1:0]          cmd_len_o,
  input  logic                    status_load_i,
  input  logic [7:0]              status_byte_i,
  input  logic                    count_load_i,
  input  logic signed [CNT_W-1:0] count_val_i,
  output logic signed [CNT_W-1:0] count_o,
  input  logic                    flush_i,
  input  logic                    int_ack_i,
  input  logic                    seq_wr_i,
  input  logic [2:0]              seq_val_i,
  output logic [2:0]              seq_step_o,
  output logic [7:0]              int_cause_o,
  output logic [FLAG_W-1:0]       fifo_flags_o,
  output logic                    irq_o,
  output logic                    overrun_o
);
  logic host_wr, data_wr, data_rd, cmd_wr;
  logic data_ovr, cmd_ovr;

  assign host_wr = fifo_wr_i & ~status_load_i;
  assign data_wr = host_wr & ~cmd_mode_i;
  assign cmd_wr  = host_wr & cmd_mode_i;
  assign data_rd = fifo_rd_i & ~status_load_i;

  pio_data_buf #(.DEPTH(DATA_DEPTH), .W(8), .CNT_W(CNT_W)) i_data (
    .clk_i, .rst_ni,
    .wr_i        (data_wr),
    .wdata_i     (fifo_wdata_i),
    .rd_i        (data_rd & ~fifo_wr_i),
    .phase_zero_i(phase_i == PHASE_DATA_OUT),
    .preload_i   (status_load_i),
    .status_i    (status_byte_i),
    .cnt_load_i  (count_load_i),
    .cnt_val_i   (count_val_i),
    .rdata_o     (fifo_rdata_o),
    .count_o     (count_o),
    .overrun_o   (data_ovr)
  );

  pio_cmd_buf #(.DEPTH(CMD_DEPTH), .W(8)) i_cmd (
    .clk_i, .rst_ni,
    .wr_i     (cmd_wr),
    .wdata_i  (fifo_wdata_i),
    .take_i   (cmd_take_i),
    .raddr_i  (cmd_raddr_i),
    .rdata_o  (cmd_rdata_o),
    .len_o    (cmd_len_o),
    .overrun_o(cmd_ovr)
  );

  pio_int_regs #(.FLAG_W(FLAG_W)) i_regs (
    .clk_i, .rst_ni,
    .flush_i  (flush_i),
    .ack_i    (int_ack_i),
    .raise_i  (status_load_i),
    .seq_wr_i (seq_wr_i),
    .seq_val_i(seq_val_i),
    .cause_o  (int_cause_o),
    .seq_o    (seq_step_o),
    .flags_o  (fifo_flags_o),
    .irq_o    (irq_o)
  );

  assign overrun_o = data_ovr | cmd_ovr;

  assert_ovr_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> (!overrun_o || $past(fifo_wr_i)));
  assert_preload_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_load_i && !count_load_i) |=> (count_o == CNT_W'(2) && irq_o));
  assert_preload_beats_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_load_i && !cmd_take_i) |=> ($stable(cmd_len_o) && !overrun_o));
endmodule

// File: tb/test_pio_cmd_fifo.sv
module test_pio_cmd_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CDEPTH = 32;

  logic clk_i = 0, rst_ni = 0;
  logic fifo_wr_i = 0, fifo_rd_i = 0, cmd_mode_i = 0, cmd_take_i = 0;
  logic [7:0] fifo_wdata_i = 0, status_byte_i = 0;
  logic [2:0] phase_i = 3'd1, seq_val_i = 0;
  logic [4:0] cmd_raddr_i = 0;
  logic status_load_i = 0, count_load_i = 0, flush_i = 0, int_ack_i = 0, seq_wr_i = 0;
  logic signed [16:0] count_val_i = 0;
  logic [7:0] fifo_rdata_o, cmd_rdata_o, int_cause_o;
  logic [5:0] cmd_len_o;
  logic signed [16:0] count_o;
  logic [2:0] seq_step_o;
  logic [4:0] fifo_flags_o;
  logic irq_o, overrun_o;

  pio_cmd_fifo i_pio_cmd_fifo (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int tests_run = 0, tests_failed = 0;
  bit done = 0;

  byte unsigned dq[$];
  byte unsigned cq[$];
  int used = 0, cnt = 0, flags = 0, cause = 0, seq = 0, rd = 0;
  bit irq = 0, ovr = 0;

  task automatic chk(string req, string what, int act, int exp);
    tests_run++;
    if (act != exp) begin
      tests_failed++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    ovr = 0;
    if (flush_i) cause = 8;
    else if (int_ack_i) cause = 0;
    if (flush_i) seq = 0;
    else if (seq_wr_i) seq = int'(seq_val_i);
    if (status_load_i) flags = 2;
    else if (flush_i) flags = 0;
    if (status_load_i) irq = 1;
    else if (int_ack_i) irq = 0;
    if (status_load_i) begin
      dq = {status_byte_i, 8'h00};
      used = 2;
      cnt = 2;
    end else if (fifo_wr_i) begin
      if (cmd_mode_i) begin
        if (!cmd_take_i) begin
          if (cq.size() < CDEPTH) cq.push_back(fifo_wdata_i);
          else ovr = 1;
        end
      end else if (used == DEPTH - 1) begin
        ovr = 1;
      end else begin
        dq.push_back(fifo_wdata_i);
        used++;
        cnt++;
      end
    end else if (fifo_rd_i) begin
      if (phase_i == 3'd0) rd = 0;
      else if (dq.size() > 0) begin
        rd = int'(dq.pop_front());
        cnt--;
      end
      if (dq.size() == 0) used = 0;
    end
    if (cmd_take_i) cq.delete();
    if (count_load_i) cnt = int'(count_val_i);
  endtask

  task automatic compare_all();
    chk("R4", "rdata", int'(fifo_rdata_o), rd);
    chk("R2", "count", int'(count_o), cnt);
    chk("R7", "flags", int'(fifo_flags_o), flags);
    chk("R8", "cause", int'(int_cause_o), cause);
    chk("R9", "seq", int'(seq_step_o), seq);
    chk("R9", "irq", int'(irq_o), int'(irq));
    chk("R3", "cmd_len", int'(cmd_len_o), cq.size());
    chk("R3", "cmd_rdata", int'(cmd_rdata_o),
        (int'(cmd_raddr_i) < cq.size()) ? int'(cq[cmd_raddr_i]) : 0);
    chk("R2", "overrun", int'(overrun_o), int'(ovr));
  endtask

  task automatic cyc();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare_all();
    fifo_wr_i = 0; fifo_rd_i = 0; cmd_take_i = 0; status_load_i = 0;
    count_load_i = 0; flush_i = 0; int_ack_i = 0; seq_wr_i = 0;
  endtask

  task automatic wr(input logic [7:0] b);
    fifo_wr_i = 1; fifo_wdata_i = b; cyc();
  endtask

  task automatic rdb();
    fifo_rd_i = 1; cyc();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset values
    chk("R1", "rdata", int'(fifo_rdata_o), 0);
    chk("R1", "count", int'(count_o), 0);
    chk("R1", "flags", int'(fifo_flags_o), 0);
    chk("R1", "cause", int'(int_cause_o), 0);
    chk("R1", "irq", int'(irq_o), 0);
    chk("R1", "cmd_len", int'(cmd_len_o), 0);
    chk("R1", "overrun", int'(overrun_o), 0);
    rst_ni = 1;
    cyc();

    for (int i = 0; i < 5; i++) wr(8'hA0 + 8'(i));
    for (int i = 0; i < 5; i++) rdb();
    chk("R4", "last byte", int'(fifo_rdata_o), 8'hA4);
    rdb();
    chk("R4", "empty read holds", int'(fifo_rdata_o), 8'hA4);

    wr(8'h11); wr(8'h22);
    phase_i = 3'd0; rdb();
    chk("R5", "data-out read", int'(fifo_rdata_o), 0);
    chk("R5", "count kept", int'(count_o), 2);
    phase_i = 3'd2; rdb(); rdb();
    chk("R5", "byte after data-out", int'(fifo_rdata_o), 8'h22);

    for (int i = 0; i < 16; i++) wr(8'h40 + 8'(i));
    for (int i = 0; i < 3; i++) rdb();
    wr(8'hEE);
    chk("R6", "no room before drain", int'(overrun_o), 1);
    for (int i = 0; i < 12; i++) rdb();
    for (int i = 0; i < 15; i++) wr(8'h60 + 8'(i));
    chk("R6", "refill after drain", int'(count_o), 15);
    for (int i = 0; i < 15; i++) rdb();

    count_load_i = 1; count_val_i = -17'sd4; cyc();
    wr(8'h01);
    count_load_i = 1; count_val_i = 17'sd9; fifo_wr_i = 1; fifo_wdata_i = 8'h02; cyc();
    chk("R10", "count load wins", int'(count_o), 9);
    rdb(); rdb();

    cmd_mode_i = 1;
    for (int i = 0; i < 33; i++) begin
      cmd_raddr_i = 5'(i);
      wr(8'h80 + 8'(i));
    end
    for (int i = 0; i < 32; i++) begin cmd_raddr_i = 5'(i); cyc(); end
    cmd_take_i = 1; fifo_wr_i = 1; fifo_wdata_i = 8'h55; cyc();
    chk("R3", "take wins", int'(cmd_len_o), 0);
    wr(8'h99);
    cmd_mode_i = 0;
    cmd_raddr_i = 0; cyc();

    seq_wr_i = 1; seq_val_i = 3'd5; cyc();
    status_byte_i = 8'h02; status_load_i = 1; fifo_wr_i = 1; fifo_wdata_i = 8'h77; cyc();
    rdb();
    chk("R10", "preload drops write", int'(fifo_rdata_o), 8'h02);
    rdb();
    chk("R7", "message byte", int'(fifo_rdata_o), 0);
    flush_i = 1; cyc();
    chk("R8", "flush cause", int'(int_cause_o), 8);
    int_ack_i = 1; cyc();
    status_load_i = 1; flush_i = 1; int_ack_i = 1; status_byte_i = 8'h30; cyc();
    chk("R8", "flags with preload", int'(fifo_flags_o), 2);
    rdb(); rdb();
    wr(8'h5A);
    fifo_wr_i = 1; fifo_rd_i = 1; fifo_wdata_i = 8'h5B; cyc();
    chk("R10", "write over read", int'(count_o), 2);
    rdb(); rdb();
    int_ack_i = 1; cyc();
    repeat (3) cyc();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule